// File: doc/BRIEF.md
# Serial trellis check-node soft-in soft-out unit

This unit performs the check-node work of one row inside a layered LDPC decoder. The soft values of the row arrive one per cycle, already routed by an external permuter. For each edge the unit removes the extrinsic value that the same edge produced in the previous pass, giving the check input rho. It runs the forward (alpha) recursion on the fly while pushing every rho and every alpha onto two separate stacks. Once the last input has been taken, the backward (beta) recursion replays the inputs from the top of the input stack. A third boxplus unit combines each popped alpha with the running beta to form the new extrinsic value of every edge.

Each new extrinsic value is clipped to a narrow stored format and written back to an internal extrinsic store, at the row's base address plus the edge index. The updated posterior rho + extrinsic is sent out alongside it. Both outputs appear for the edges in descending index order, because that is the order the backward pass pops them. A row of degree d occupies the unit for exactly 2·d cycles when inputs arrive without gaps. The store is cleared by reset or by a clear pulse before decoding a new frame.

Top module: `trellis_cn_siso`

## Requirements
- R1: After reset `busy_o` and `out_valid_o` are low, and every stored extrinsic value reads as zero.
- R2: For input edge k the check input is rho_k = sat7(post_k − old_ext_k). The emitted posterior is sat7(rho_k + new_ext_k). Here sat7 clips to [−64, 63], and values are two's complement with the LSB worth 0.5.
- R3: The boxplus a⊞b equals max(0, a+b) − max(a, b) + c(a+b) − c(a−b), clipped to [−64, 63], where c(v) is 1 LSB when v = 0 and zero otherwise.
- R4: With alpha_0 = rho_0, alpha_k = alpha_{k−1} ⊞ rho_k and beta_{d−1} = rho_{d−1}, beta_k = rho_k ⊞ beta_{k+1}, the raw extrinsic value is beta_1 for edge 0 and alpha_{d−2} for edge d−1. For every other edge i it is alpha_{i−1} ⊞ beta_{i+1}.
- R5: The raw extrinsic value is clipped to [−16, 15] (5 bits). It is then output on `ext_o` sign-extended to 7 bits and written to store address base + i. That value is read back as the old extrinsic value of that address in the next row that uses it.
- R6: Results come out for edges d−1, d−2, …, 0 on consecutive cycles, with `out_idx_o` carrying the edge index.
- R7: The first result is valid in the cycle after the edge that accepts the last input. `out_valid_o` stays high for exactly d cycles, so a gap-free row spans 2·d cycles. `busy_o` falls together with the last result.
- R8: Inputs are taken only in the input phase while `in_valid_i` is high. A low cycle stalls the row without altering the results. `in_valid_i` and `post_i` have no effect while idle or while results are being emitted.
- R9: `start_i` is accepted only while idle, and it latches `deg_i` and `base_i`. A start pulse during a busy row is ignored.
- R10: A `clr_i` pulse sets every stored extrinsic value to zero.
- R11: Degrees from 2 up to MAX_DEG are supported. The addresses base + i may reach MEM_DEPTH − 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| clr_i | input | 1 | Clears the extrinsic store |
| start_i | input | 1 | Begins a row when idle |
| deg_i | input | DEG_W (5) | Check degree of the row |
| base_i | input | ADDR_W (7) | Base address of the row in the extrinsic store |
| in_valid_i | input | 1 | Qualifies `post_i` |
| post_i | input | LLR_W (7) | Incoming posterior soft value |
| busy_o | output | 1 | A row is in progress |
| out_valid_o | output | 1 | Qualifies the result outputs |
| out_idx_o | output | DEG_W (5) | Edge index of the current result |
| ext_o | output | LLR_W (7) | New extrinsic value, sign-extended from 5 bits |
| post_o | output | LLR_W (7) | Updated posterior value |

## Verification
The bench builds the unit with its defaults: 7-bit soft values, 5-bit stored extrinsics, a maximum degree of 24 and an 88-entry store. With these values both degree extremes (2 and 24) are reachable, and a 24-edge row placed at base 64 reaches the last store address. The 7-bit range is narrow enough that generated posteriors drive rho, the boxplus and the posterior sums into clipping. Repeating a row at the same base exercises the read-back of saturated 5-bit extrinsics, and a clear pulse followed by the same row shows the store returning to zero.

// File: rtl/siso_pkg.sv
package siso_pkg;
    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_IN   = 2'd1,
        PH_OUT  = 2'd2
    } phase_e;
endpackage

// File: rtl/boxplus_unit.sv
module boxplus_unit #(
    parameter int W = 7
) (
    input  logic signed [W-1:0] a_i,
    input  logic signed [W-1:0] b_i,
    output logic signed [W-1:0] q_o
);
    localparam int IW = W + 2;
    localparam logic signed [IW-1:0] MAXV = IW'((1 << (W-1)) - 1);
    localparam logic signed [IW-1:0] MINV = -MAXV - IW'(1);

    logic signed [IW-1:0] ae, be, sum, dif, mx0, mxab, corr, raw;

    always_comb begin
        ae   = IW'(a_i);
        be   = IW'(b_i);
        sum  = ae + be;
        dif  = ae - be;
        mx0  = (sum > 0) ? sum : '0;
        mxab = (ae > be) ? ae : be;
        corr = '0;
        if (sum == 0) corr = corr + IW'(1);
        if (dif == 0) corr = corr - IW'(1);
        raw  = mx0 - mxab + corr;
        if (raw > MAXV)      q_o = MAXV[W-1:0];
        else if (raw < MINV) q_o = MINV[W-1:0];
        else                 q_o = raw[W-1:0];
    end
endmodule

// File: rtl/lifo_stack.sv
module lifo_stack #(
    parameter int W     = 7,
    parameter int DEPTH = 24
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push_i,
    input  logic         pop_i,
    input  logic [W-1:0] data_i,
    output logic [W-1:0] top_o
);
    localparam int PW = $clog2(DEPTH + 1);

    logic [W-1:0]  mem_q [DEPTH];
    logic [PW-1:0] ptr_q;
    logic [PW-1:0] top_idx;

    always_comb begin
        top_idx = ptr_q - PW'(1);
        top_o   = (ptr_q != '0) ? mem_q[top_idx] : '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ptr_q <= '0;
        end else if (push_i && (int'(ptr_q) < DEPTH)) begin
            mem_q[ptr_q] <= data_i;
            ptr_q        <= ptr_q + PW'(1);
        end else if (pop_i && (ptr_q != '0)) begin
            ptr_q <= ptr_q - PW'(1);
        end
    end
endmodule

// File: rtl/ext_store.sv
module ext_store #(
    parameter int W      = 5,
    parameter int DEPTH  = 88,
    parameter int ADDR_W = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr_i,
    input  logic              we_i,
    input  logic [ADDR_W-1:0] waddr_i,
    input  logic [W-1:0]      wdata_i,
    input  logic [ADDR_W-1:0] raddr_i,
    output logic [W-1:0]      rdata_o
);
    logic [W-1:0] mem_q [DEPTH];

    always_comb begin
        rdata_o = (int'(raddr_i) < DEPTH) ? mem_q[raddr_i] : '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
        end else if (clr_i) begin
            for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
        end else if (we_i && (int'(waddr_i) < DEPTH)) begin
            mem_q[waddr_i] <= wdata_i;
        end
    end
endmodule

// File: rtl/trellis_cn_siso.sv
module trellis_cn_siso #(
    parameter int LLR_W     = 7,
    parameter int EXT_W     = 5,
    parameter int MAX_DEG   = 24,
    parameter int MEM_DEPTH = 88,
    parameter int DEG_W     = $clog2(MAX_DEG + 1),
    parameter int ADDR_W    = $clog2(MEM_DEPTH)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    clr_i,
    input  logic                    start_i,
    input  logic [DEG_W-1:0]        deg_i,
    input  logic [ADDR_W-1:0]       base_i,
    input  logic                    in_valid_i,
    input  logic signed [LLR_W-1:0] post_i,
    output logic                    busy_o,
    output logic                    out_valid_o,
    output logic [DEG_W-1:0]        out_idx_o,
    output logic signed [LLR_W-1:0] ext_o,
    output logic signed [LLR_W-1:0] post_o
);
    import siso_pkg::*;

    localparam int SW = LLR_W + 1;
    localparam logic signed [SW-1:0]    LMAX = SW'((1 << (LLR_W-1)) - 1);
    localparam logic signed [SW-1:0]    LMIN = -LMAX - SW'(1);
    localparam logic signed [LLR_W-1:0] EMAX = LLR_W'((1 << (EXT_W-1)) - 1);
    localparam logic signed [LLR_W-1:0] EMIN = -EMAX - LLR_W'(1);

    typedef struct packed {
        phase_e                  ph;
        logic [DEG_W-1:0]        deg;
        logic [ADDR_W-1:0]       base;
        logic [DEG_W-1:0]        cnt;
        logic signed [LLR_W-1:0] alpha;
        logic signed [LLR_W-1:0] beta;
        logic                    ov;
        logic [DEG_W-1:0]        oidx;
        logic signed [LLR_W-1:0] oext;
        logic signed [LLR_W-1:0] opost;
    } siso_state_t;

    siso_state_t s_d, s_q;

    function automatic logic signed [LLR_W-1:0] clip_llr(input logic signed [SW-1:0] v);
        if (v > LMAX)      return LMAX[LLR_W-1:0];
        else if (v < LMIN) return LMIN[LLR_W-1:0];
        else               return v[LLR_W-1:0];
    endfunction

    function automatic logic signed [EXT_W-1:0] clip_ext(input logic signed [LLR_W-1:0] v);
        if (v > EMAX)      return EMAX[EXT_W-1:0];
        else if (v < EMIN) return EMIN[EXT_W-1:0];
        else               return v[EXT_W-1:0];
    endfunction

    // storage and operator instances
    logic [ADDR_W-1:0]       addr;
    logic signed [EXT_W-1:0] old_ext5;
    logic signed [EXT_W-1:0] new_ext5;
    logic signed [LLR_W-1:0] rho, in_top, a_top;
    logic signed [LLR_W-1:0] bp_alpha, bp_beta, bp_ext;
    logic signed [LLR_W-1:0] a_new, ext_raw, ext7;
    logic                    push_in, push_a, pop_in, pop_a, we;

    assign addr = s_q.base + ADDR_W'(s_q.cnt);

    ext_store #(.W(EXT_W), .DEPTH(MEM_DEPTH), .ADDR_W(ADDR_W)) u_store (
        .clk(clk), .rst_n(rst_n), .clr_i(clr_i),
        .we_i(we), .waddr_i(addr), .wdata_i(new_ext5),
        .raddr_i(addr), .rdata_o(old_ext5)
    );

    lifo_stack #(.W(LLR_W), .DEPTH(MAX_DEG)) u_in_stack (
        .clk(clk), .rst_n(rst_n), .push_i(push_in), .pop_i(pop_in),
        .data_i(rho), .top_o(in_top)
    );

    lifo_stack #(.W(LLR_W), .DEPTH(MAX_DEG)) u_alpha_stack (
        .clk(clk), .rst_n(rst_n), .push_i(push_a), .pop_i(pop_a),
        .data_i(a_new), .top_o(a_top)
    );

    boxplus_unit #(.W(LLR_W)) u_bp_alpha (.a_i(s_q.alpha), .b_i(rho),    .q_o(bp_alpha));
    boxplus_unit #(.W(LLR_W)) u_bp_beta  (.a_i(in_top),    .b_i(s_q.beta), .q_o(bp_beta));
    boxplus_unit #(.W(LLR_W)) u_bp_ext   (.a_i(a_top),     .b_i(s_q.beta), .q_o(bp_ext));

    always_comb begin
        s_d      = s_q;
        s_d.ov   = 1'b0;
        push_in  = 1'b0;
        push_a   = 1'b0;
        pop_in   = 1'b0;
        pop_a    = 1'b0;
        we       = 1'b0;
        rho      = clip_llr(SW'(post_i) - SW'(old_ext5));
        a_new    = (s_q.cnt == '0) ? rho : bp_alpha;
        ext_raw  = (s_q.cnt == s_q.deg - DEG_W'(1)) ? a_top :
                   (s_q.cnt == '0)                  ? s_q.beta : bp_ext;
        new_ext5 = clip_ext(ext_raw);
        ext7     = LLR_W'(new_ext5);

        unique case (s_q.ph)
            PH_IDLE: begin
                if (start_i) begin
                    s_d.ph   = PH_IN;
                    s_d.deg  = deg_i;
                    s_d.base = base_i;
                    s_d.cnt  = '0;
                end
            end
            PH_IN: begin
                if (in_valid_i) begin
                    push_in   = 1'b1;
                    s_d.alpha = a_new;
                    if (s_q.cnt == s_q.deg - DEG_W'(1)) begin
                        s_d.ph = PH_OUT;
                    end else begin
                        push_a  = 1'b1;
                        s_d.cnt = s_q.cnt + DEG_W'(1);
                    end
                end
            end
            PH_OUT: begin
                pop_in    = 1'b1;
                pop_a     = (s_q.cnt != '0);
                we        = 1'b1;
                s_d.beta  = (s_q.cnt == s_q.deg - DEG_W'(1)) ? in_top : bp_beta;
                s_d.ov    = 1'b1;
                s_d.oidx  = s_q.cnt;
                s_d.oext  = ext7;
                s_d.opost = clip_llr(SW'(in_top) + SW'(ext7));
                if (s_q.cnt == '0) s_d.ph  = PH_IDLE;
                else               s_d.cnt = s_q.cnt - DEG_W'(1);
            end
            default: s_d.ph = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q    <= '0;
            s_q.ph <= PH_IDLE;
        end else begin
            s_q <= s_d;
        end
    end

    assign busy_o      = (s_q.ph != PH_IDLE);
    assign out_valid_o = s_q.ov;
    assign out_idx_o   = s_q.oidx;
    assign ext_o       = s_q.oext;
    assign post_o      = s_q.opost;
endmodule

// File: rtl/trellis_cn_siso_checker.sv
module trellis_cn_siso_checker #(
    parameter int LLR_W = 7,
    parameter int EXT_W = 5,
    parameter int DEG_W = 5
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    start_i,
    input logic                    busy_o,
    input logic                    out_valid_o,
    input logic [DEG_W-1:0]        out_idx_o,
    input logic signed [LLR_W-1:0] ext_o
);
    localparam int EHI = (1 << (EXT_W-1)) - 1;
    localparam int ELO = -(1 << (EXT_W-1));

    // R5: emitted extrinsic stays inside the stored 5-bit range
    p_ext_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid_o |-> (int'(ext_o) <= EHI && int'(ext_o) >= ELO));

    // R6: edge indices descend one per cycle
    p_desc_order_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid_o && out_idx_o != '0) |=>
            (out_valid_o && out_idx_o == $past(out_idx_o) - DEG_W'(1)));

    // R7: results stop after edge zero
    p_end_after_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid_o && out_idx_o == '0) |=> !out_valid_o);

    // R7: the unit remains busy until the final result
    p_busy_during_out_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid_o && out_idx_o != '0) |-> busy_o);

    // R9: a row begins only from a start pulse
    p_start_rise_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_o) |-> $past(start_i));
endmodule

bind trellis_cn_siso trellis_cn_siso_checker #(
    .LLR_W(LLR_W), .EXT_W(EXT_W), .DEG_W(DEG_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .busy_o(busy_o),
    .out_valid_o(out_valid_o), .out_idx_o(out_idx_o), .ext_o(ext_o)
);

// File: tb/trellis_cn_siso_tb.sv
module trellis_cn_siso_tb;
    localparam int LLR_W = 7;
    localparam int EXT_W = 5;
    localparam int MAX_DEG = 24;
    localparam int MEM_DEPTH = 88;
    localparam int DEG_W = $clog2(MAX_DEG + 1);
    localparam int ADDR_W = $clog2(MEM_DEPTH);

    localparam int NV = 8;
    // deg, base, seed
    localparam int VEC [NV][3] = '{
        '{6, 0, 3}, '{6, 0, 9}, '{2, 10, 5}, '{24, 20, 7},
        '{24, 64, 11}, '{7, 44, 2}, '{5, 50, 13}, '{12, 30, 21}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic clr_i = 1'b0;
    logic start_i = 1'b0;
    logic [DEG_W-1:0] deg_i = '0;
    logic [ADDR_W-1:0] base_i = '0;
    logic in_valid_i = 1'b0;
    logic signed [LLR_W-1:0] post_i = '0;
    logic busy_o, out_valid_o;
    logic [DEG_W-1:0] out_idx_o;
    logic signed [LLR_W-1:0] ext_o, post_o;

    int checks = 0;
    int errors = 0;
    int mdl [MEM_DEPTH];
    int posts [MAX_DEG];
    int exp_ext [MAX_DEG];
    int exp_post [MAX_DEG];

    always #2.5 clk = ~clk;

    trellis_cn_siso u_dut (
        .clk(clk), .rst_n(rst_n), .clr_i(clr_i), .start_i(start_i),
        .deg_i(deg_i), .base_i(base_i), .in_valid_i(in_valid_i), .post_i(post_i),
        .busy_o(busy_o), .out_valid_o(out_valid_o), .out_idx_o(out_idx_o),
        .ext_o(ext_o), .post_o(post_o)
    );

    task automatic chk(input bit ok, input string req, input int act, input int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, expv);
        end
    endtask

    function automatic int clip(input int v, input int lo, input int hi);
        return (v > hi) ? hi : (v < lo) ? lo : v;
    endfunction

    function automatic int bplus(input int a, input int b);
        int s = a + b;
        int d = a - b;
        int r = ((s > 0) ? s : 0) - ((a > b) ? a : b) + ((s == 0) ? 1 : 0) - ((d == 0) ? 1 : 0);
        return clip(r, -64, 63);
    endfunction

    task automatic gen_posts(input int d, input int seed);
        for (int k = 0; k < d; k++)
            posts[k] = ((seed * 37 + k * 53 + k * k * 11) % 128) - 64;
    endtask

    // reference model: R2, R3, R4, R5
    task automatic model_row(input int d, input int base);
        int rho [MAX_DEG];
        int al [MAX_DEG];
        int be [MAX_DEG];
        int raw;
        for (int k = 0; k < d; k++) rho[k] = clip(posts[k] - mdl[base + k], -64, 63);
        al[0] = rho[0];
        for (int k = 1; k < d; k++) al[k] = bplus(al[k-1], rho[k]);
        be[d-1] = rho[d-1];
        for (int k = d - 2; k >= 0; k--) be[k] = bplus(rho[k], be[k+1]);
        for (int i = 0; i < d; i++) begin
            if (i == 0)          raw = be[1];
            else if (i == d - 1) raw = al[d-2];
            else                 raw = bplus(al[i-1], be[i+1]);
            exp_ext[i]  = clip(raw, -16, 15);
            exp_post[i] = clip(rho[i] + exp_ext[i], -64, 63);
            mdl[base + i] = exp_ext[i];
        end
    endtask

    task automatic run_row(input int d, input int base, input bit use_gen, input int seed,
                           input int gap_at, input bit busy_start, input bit out_noise);
        if (use_gen) gen_posts(d, seed);
        model_row(d, base);
        @(negedge clk);
        start_i = 1'b1; deg_i = DEG_W'(d); base_i = ADDR_W'(base); in_valid_i = 1'b0;
        @(negedge clk);
        start_i = 1'b0;
        for (int k = 0; k < d; k++) begin
            if (k == gap_at) begin
                in_valid_i = 1'b0; post_i = 7'sd33;
                @(negedge clk);
            end
            in_valid_i = 1'b1;
            post_i = LLR_W'(posts[k]);
            if (busy_start && k == 1) begin
                start_i = 1'b1; deg_i = DEG_W'(2); base_i = '0;
            end
            @(negedge clk);
            start_i = 1'b0;
        end
        in_valid_i = out_noise;
        post_i = out_noise ? 7'sd63 : '0;
        @(negedge clk);
        for (int j = 0; j < d; j++) begin
            int i = d - 1 - j;
            chk(out_valid_o == 1'b1, "R7 result valid", int'(out_valid_o), 1);
            chk(int'(out_idx_o) == i, "R6 edge order", int'(out_idx_o), i);
            chk(int'(ext_o) == exp_ext[i], "R4/R5 extrinsic", int'(ext_o), exp_ext[i]);
            chk(int'(post_o) == exp_post[i], "R2 posterior", int'(post_o), exp_post[i]);
            @(negedge clk);
        end
        in_valid_i = 1'b0;
        chk(out_valid_o == 1'b0, "R7 exactly d results", int'(out_valid_o), 0);
        chk(busy_o == 1'b0, "R9 row ends idle", int'(busy_o), 0);
    endtask

    initial begin
        #(5.0 * 150000);
        errors++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        for (int a = 0; a < MEM_DEPTH; a++) mdl[a] = 0;
        #12;
        // R1: reset state
        chk(busy_o == 1'b0, "R1 busy in reset", int'(busy_o), 0);
        chk(out_valid_o == 1'b0, "R1 valid in reset", int'(out_valid_o), 0);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(busy_o == 1'b0, "R1 busy after reset", int'(busy_o), 0);

        // R8: input activity while idle has no effect
        in_valid_i = 1'b1; post_i = 7'sd50;
        repeat (3) begin
            @(negedge clk);
            chk(out_valid_o == 1'b0 && busy_o == 1'b0, "R8 idle input ignored",
                int'(out_valid_o), 0);
        end
        in_valid_i = 1'b0;

        // table walk: R2..R6, R11 (degree 2, 24, top address 87)
        for (int v = 0; v < NV; v++)
            run_row(VEC[v][0], VEC[v][1], 1'b1, VEC[v][2], -1, 1'b0, 1'b0);

        // R8: stall in the input phase, noise in the output phase
        run_row(9, 0, 1'b1, 17, 4, 1'b0, 1'b1);
        // R9: start during a busy row is ignored
        run_row(8, 70, 1'b1, 23, -1, 1'b1, 1'b0);

        // R3/R2 saturation: large equal inputs
        for (int k = 0; k < 3; k++) posts[k] = 63;
        run_row(3, 80, 1'b0, 0, -1, 1'b0, 1'b0);
        for (int k = 0; k < 3; k++) posts[k] = -64;
        run_row(3, 80, 1'b0, 0, -1, 1'b0, 1'b0);

        // R10: clear returns every stored value to zero
        @(negedge clk);
        clr_i = 1'b1;
        @(negedge clk);
        clr_i = 1'b0;
        for (int a = 0; a < MEM_DEPTH; a++) mdl[a] = 0;
        run_row(6, 0, 1'b1, 3, -1, 1'b0, 1'b0);
        run_row(24, 64, 1'b1, 11, -1, 1'b0, 1'b0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule